// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper

This block sits between a CPU's 16-bit address bus and the two cartridge memories. Stores into the lower half of the address map never reach a memory. They program a small set of control registers instead. Loads are translated into physical addresses for the ROM and the external RAM. The lower 16 KiB ROM window always shows bank 0. The upper 16 KiB window shows the selected bank, masked so that it stays within the installed ROM.

The control state is a 5-bit low bank field, a 2-bit shared field, a 2-bit RAM bank, a RAM-enable flag and a banking-mode bit. The shared field feeds either the two upper ROM bank bits or the RAM bank, depending on the mode. Address outputs are combinational from the CPU address and the current control state. A store takes effect on the clock edge that samples it. The asynchronous active-low reset is released synchronously inside the block.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, the mode is 0 (ROM banking) and RAM is disabled.
- R2: A store with cpu_addr[15:13]=0 and data 0x0A enables RAM, and one with data 0x00 disables it. Any other data value leaves the enable unchanged.
- R3: A store with cpu_addr[15:13]=1 loads data[4:0] into ROM bank bits [4:0], with 0 replaced by 1. ROM bank bits [6:5] keep their value.
- R4: A store with cpu_addr[15:13]=2 in mode 0 loads data[1:0] into ROM bank bits [6:5] and leaves the RAM bank unchanged.
- R5: A store with cpu_addr[15:13]=2 in mode 1 loads data[1:0] into the RAM bank and leaves the ROM bank unchanged.
- R6: A store with cpu_addr[15:13]=3 sets the mode to data[0]. Data[0]=1 also clears ROM bank bits [6:5]. Data[0]=0 also forces the RAM bank to 0.
- R7: The ROM bank used for translation is the 7-bit bank ANDed with ROM_BANKS-1 (default ROM_BANKS=64).
- R8: When cpu_addr[14]=0, rom_addr equals cpu_addr[13:0] with upper bits zero.
- R9: When cpu_addr[14]=1, rom_addr equals the wrapped bank times 0x4000 plus cpu_addr[13:0].
- R10: ram_addr equals RAM bank times 0x2000 plus cpu_addr[12:0]. ram_ce is 1 only when cpu_addr[15:13]=5 (0xA000-0xBFFF) and RAM is enabled.
- R11: No control state changes when cpu_we is 0 or when cpu_addr[15]=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU store data |
| cpu_we | input | 1 | CPU store strobe |
| rom_addr | output | 21 | Physical ROM byte address |
| ram_addr | output | 15 | Physical external RAM byte address |
| ram_ce | output | 1 | External RAM chip enable |

## Verification
Translated addresses and the RAM enable are combinational, so a load's results are due in the same cycle as the address. A store changes the mapping from the clock edge that samples it. The bench therefore applies each store so that it straddles exactly one rising edge. It presents each load address half a cycle before an edge, while the strobe is low. The monitor compares the outputs two nanoseconds after that edge, when no state change can still be in flight. The first two edges after reset release are left idle, because the reset synchronizer holds the registers in reset during that time.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int CBM_LO_W      = 5;
  localparam int CBM_HI_W      = 2;
  localparam int CBM_BANK_W    = CBM_LO_W + CBM_HI_W;
  localparam int CBM_RAMB_W    = 2;
  localparam int CBM_WIN_W     = 14;
  localparam int CBM_RAM_OFF_W = 13;
  localparam int CBM_ROM_AW    = CBM_BANK_W + CBM_WIN_W;
  localparam int CBM_RAM_AW    = CBM_RAMB_W + CBM_RAM_OFF_W;
  localparam int CBM_NREG      = 4;
  localparam int CBM_SEL_W     = 3;

  localparam logic [7:0] CBM_RAM_ON  = 8'h0A;
  localparam logic [7:0] CBM_RAM_OFF = 8'h00;
  localparam logic [CBM_SEL_W-1:0] CBM_RAM_WIN = 3'd5;

  typedef enum logic {
    MODE_ROM = 1'b0,
    MODE_RAM = 1'b1
  } cbm_mode_e;

  typedef enum logic [1:0] {
    REG_RAMEN  = 2'd0,
    REG_BANKLO = 2'd1,
    REG_SHARED = 2'd2,
    REG_MODE   = 2'd3
  } cbm_reg_e;

  typedef struct packed {
    logic                  ram_en;
    cbm_mode_e             mode;
    logic [CBM_HI_W-1:0]   hi2;
    logic [CBM_RAMB_W-1:0] ram_bank;
    logic [CBM_LO_W-1:0]   lo5;
  } cbm_state_t;
endpackage

// File: rtl/cbm_rst_sync.sv
module cbm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/cbm_wr_decode.sv
module cbm_wr_decode
  import cbm_pkg::*;
(
  input  logic                 we,
  input  logic [CBM_SEL_W-1:0] addr_hi,
  output logic [CBM_NREG-1:0]  wr_sel
);
  for (genvar g = 0; g < CBM_NREG; g++) begin : g_sel
    assign wr_sel[g] = we && (addr_hi == CBM_SEL_W'(g));
  end
endmodule

// File: rtl/cbm_ctrl_regs.sv
module cbm_ctrl_regs
  import cbm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CBM_NREG-1:0] wr_sel,
  input  logic [7:0]          wdata,
  output cbm_state_t          state_q
);
  cbm_state_t state_d;
  logic       state_en;
  cbm_state_t state_rst;

  always_comb begin
    state_rst          = '0;
    state_rst.lo5      = CBM_LO_W'(1);
    state_rst.mode     = MODE_ROM;
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    if (wr_sel[REG_RAMEN]) begin
      if (wdata == CBM_RAM_ON)       state_d.ram_en = 1'b1;
      else if (wdata == CBM_RAM_OFF) state_d.ram_en = 1'b0;
    end
    if (wr_sel[REG_BANKLO]) begin
      if (wdata[CBM_LO_W-1:0] == '0) state_d.lo5 = CBM_LO_W'(1);
      else                           state_d.lo5 = wdata[CBM_LO_W-1:0];
    end
    if (wr_sel[REG_SHARED]) begin
      if (state_q.mode == MODE_ROM) state_d.hi2      = wdata[CBM_HI_W-1:0];
      else                          state_d.ram_bank = wdata[CBM_RAMB_W-1:0];
    end
    if (wr_sel[REG_MODE]) begin
      if (wdata[0]) begin
        state_d.mode = MODE_RAM;
        state_d.hi2  = '0;
      end else begin
        state_d.mode     = MODE_ROM;
        state_d.ram_bank = '0;
      end
    end
  end

  assign state_en = |wr_sel;

  // state register with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= state_rst;
    else if (state_en) state_q <= state_d;
  end
endmodule

// File: rtl/cbm_addr_map.sv
module cbm_addr_map
  import cbm_pkg::*;
#(
  parameter int ROM_BANKS = 64
) (
  input  cbm_state_t              state,
  input  logic [15:0]             cpu_addr,
  output logic [CBM_ROM_AW-1:0]   rom_addr,
  output logic [CBM_RAM_AW-1:0]   ram_addr,
  output logic                    ram_ce
);
  localparam logic [CBM_BANK_W-1:0] BANK_MASK = CBM_BANK_W'(ROM_BANKS - 1);

  logic [CBM_BANK_W-1:0] bank_raw;
  logic [CBM_BANK_W-1:0] bank_eff;
  logic [CBM_BANK_W-1:0] win_bank;

  always_comb begin
    bank_raw = {state.hi2, state.lo5};
    bank_eff = bank_raw & BANK_MASK;
    win_bank = cpu_addr[CBM_WIN_W] ? bank_eff : '0;
    rom_addr = {win_bank, cpu_addr[CBM_WIN_W-1:0]};
    ram_addr = {state.ram_bank, cpu_addr[CBM_RAM_OFF_W-1:0]};
    ram_ce   = state.ram_en && (cpu_addr[15:16-CBM_SEL_W] == CBM_RAM_WIN);
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int ROM_BANKS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           cpu_addr,
  input  logic [7:0]            cpu_wdata,
  input  logic                  cpu_we,
  output logic [CBM_ROM_AW-1:0] rom_addr,
  output logic [CBM_RAM_AW-1:0] ram_addr,
  output logic                  ram_ce
);
  logic                rst_sync_n;
  logic [CBM_NREG-1:0] wr_sel;
  cbm_state_t          ctl_q;

  cbm_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbm_wr_decode i_wr_decode (
    .we      (cpu_we),
    .addr_hi (cpu_addr[15:16-CBM_SEL_W]),
    .wr_sel  (wr_sel)
  );

  cbm_ctrl_regs i_ctrl_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_sel  (wr_sel),
    .wdata   (cpu_wdata),
    .state_q (ctl_q)
  );

  cbm_addr_map #(.ROM_BANKS(ROM_BANKS)) i_addr_map (
    .state    (ctl_q),
    .cpu_addr (cpu_addr),
    .rom_addr (rom_addr),
    .ram_addr (ram_addr),
    .ram_ce   (ram_ce)
  );
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk
  import cbm_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [15:0]           cpu_addr,
  input logic [7:0]            cpu_wdata,
  input logic                  cpu_we,
  input logic [CBM_ROM_AW-1:0] rom_addr,
  input logic [CBM_RAM_AW-1:0] ram_addr,
  input logic                  ram_ce,
  input cbm_state_t            st
);
  AST_LOW_WINDOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[14] |-> rom_addr == CBM_ROM_AW'(cpu_addr[13:0])); // R8

  AST_CE_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce |-> (cpu_addr[15:13] == 3'd5) && st.ram_en); // R10

  AST_RAM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce |-> ram_addr[12:0] == cpu_addr[12:0]); // R10

  AST_NO_STRAY_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_we || cpu_addr[15]) |=> $stable(st)); // R11

  AST_RAM_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[15:13] == 3'd0 && cpu_wdata == 8'h0A) |=> st.ram_en); // R2

  AST_RAM_ENABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[15:13] == 3'd0 && cpu_wdata == 8'h00) |=> !st.ram_en); // R2

  AST_LOW_BANK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st.lo5 != '0); // R3

  AST_MODE1_CLEARS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[15:13] == 3'd3 && cpu_wdata[0]) |=> (st.mode == MODE_RAM) && (st.hi2 == '0)); // R6

  AST_MODE0_RAM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[15:13] == 3'd3 && !cpu_wdata[0]) |=> (st.mode == MODE_ROM) && (st.ram_bank == '0)); // R6
endmodule

bind cart_bank_mapper cart_bank_mapper_chk i_cart_bank_mapper_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_we    (cpu_we),
  .rom_addr  (rom_addr),
  .ram_addr  (ram_addr),
  .ram_ce    (ram_ce),
  .st        (ctl_q)
);

// File: tb/test_cart_bank_mapper.sv
`timescale 1ns/1ps
module test_cart_bank_mapper;
  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_we;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        ram_ce;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [20:0] q_rom[$];
  logic [14:0] q_ram[$];
  logic        q_ce[$];
  string       q_tag[$];

  cart_bank_mapper i_cart_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_ce(ram_ce)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // driver: store straddling one rising edge
  task automatic store(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  // driver: inputs that must not count as a store
  task automatic idle_bus(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b0;
    @(negedge clk);
  endtask

  // driver: load address plus expected item for the scoreboard
  task automatic load(input logic [15:0] a, input logic [6:0] bank,
                      input logic [1:0] rbank, input logic ce, input string tag);
    logic [20:0] er;
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = a;
    er = a[14] ? {bank, a[13:0]} : {7'd0, a[13:0]};
    q_rom.push_back(er);
    q_ram.push_back({rbank, a[12:0]});
    q_ce.push_back(ce);
    q_tag.push_back(tag);
    @(posedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_rom.size() > 0) begin
        logic [20:0] er;
        logic [14:0] ea;
        logic        ec;
        string       t;
        er = q_rom.pop_front(); ea = q_ram.pop_front();
        ec = q_ce.pop_front();  t  = q_tag.pop_front();
        checks++;
        if (rom_addr !== er || ram_addr !== ea || ram_ce !== ec) begin
          errors++;
          $display("FAIL %s: rom=%h ram=%h ce=%b expected rom=%h ram=%h ce=%b",
                   t, rom_addr, ram_addr, ram_ce, er, ea, ec);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    load(16'h4000, 7'd1, 2'd0, 1'b0, "R1 reset bank 1");
    load(16'hA000, 7'd1, 2'd0, 1'b0, "R1 reset RAM disabled");
    // R8 fixed lower window
    load(16'h1234, 7'd1, 2'd0, 1'b0, "R8 low window");
    load(16'h3FFF, 7'd1, 2'd0, 1'b0, "R8 low window top");
    // R2 RAM enable
    store(16'h0000, 8'h0A);
    load(16'hA010, 7'd1, 2'd0, 1'b1, "R2 enable 0x0A");
    store(16'h1FFF, 8'h55);
    load(16'hA010, 7'd1, 2'd0, 1'b1, "R2 other value keeps enable");
    store(16'h0100, 8'h00);
    load(16'hA010, 7'd1, 2'd0, 1'b0, "R2 disable 0x00");
    store(16'h0000, 8'h0A);
    // R3 low bank field, R9 upper window
    store(16'h2000, 8'h05);
    load(16'h4001, 7'd5, 2'd0, 1'b0, "R9 bank 5");
    store(16'h3000, 8'h00);
    load(16'h7FFF, 7'd1, 2'd0, 1'b0, "R3 zero becomes one");
    store(16'h2000, 8'hE3);
    load(16'h4000, 7'd3, 2'd0, 1'b0, "R3 only low 5 bits");
    // R4 upper bits in mode 0, R7 wrap at 64 banks
    store(16'h4000, 8'h01);
    load(16'h4000, 7'h23, 2'd0, 1'b0, "R4 hi bits mode 0");
    load(16'hA000, 7'h23, 2'd0, 1'b1, "R4 RAM bank untouched");
    store(16'h5000, 8'h03);
    load(16'h4000, 7'h23, 2'd0, 1'b0, "R7 bank 0x63 wraps");
    store(16'h4000, 8'h02);
    load(16'h5555, 7'h03, 2'd0, 1'b0, "R7 bank 0x43 wraps");
    store(16'h2000, 8'h00);
    load(16'h4000, 7'h01, 2'd0, 1'b0, "R3 hi kept on zero write");
    store(16'h4000, 8'h01);
    store(16'h2000, 8'h07);
    load(16'h4000, 7'h27, 2'd0, 1'b0, "R3 hi kept");
    // R6 mode 1 clears upper bits, R5 RAM banking
    store(16'h6000, 8'h01);
    load(16'h4000, 7'h07, 2'd0, 1'b0, "R6 mode 1 clears hi");
    store(16'h4000, 8'h02);
    load(16'hA005, 7'h07, 2'd2, 1'b1, "R5 RAM bank 2");
    store(16'h4000, 8'h03);
    load(16'hBFFF, 7'h07, 2'd3, 1'b1, "R10 RAM bank 3 top");
    // R10 chip enable edges
    load(16'h9FFF, 7'h07, 2'd3, 1'b0, "R10 below window");
    load(16'hC000, 7'h07, 2'd3, 1'b0, "R10 above window");
    // R6 mode 0 forces RAM bank 0
    store(16'h6000, 8'h00);
    load(16'hA005, 7'h07, 2'd0, 1'b1, "R6 mode 0 RAM bank 0");
    store(16'h4000, 8'h01);
    load(16'h4000, 7'h27, 2'd0, 1'b0, "R4 mode 0 again");
    // R11 ignored stores
    store(16'h8000, 8'h00);
    store(16'hA000, 8'h00);
    store(16'hE000, 8'h01);
    load(16'hA000, 7'h27, 2'd0, 1'b1, "R11 high-half stores ignored");
    idle_bus(16'h2000, 8'h00);
    idle_bus(16'h0000, 8'h00);
    load(16'h4ABC, 7'h27, 2'd0, 1'b0, "R11 no strobe ignored");
    load(16'hB000, 7'h27, 2'd0, 1'b1, "R11 enable kept");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule